// File: doc/BRIEF.md
# Ethernet receive destination-address filter

This block judges whether a received Ethernet frame should be kept, using only the 48-bit destination address taken from the frame header. It sorts the address into broadcast, multicast or unicast. It then applies a set of acceptance flags and a single programmable station-address entry, and returns a keep/drop verdict with a reason code.

The receive path presents the destination address and pulses `valid_i` for one cycle. The verdict appears on registered outputs on the following cycle, marked by `done_o`, and stays there until the next request. The station entry is supplied as two 32-bit words, in the layout software uses to program it, together with a vector of entry-enable bits.

A complement mode turns the unicast comparison upside down, so that only frames that do not match are kept. In that mode every broadcast and multicast frame is also kept.

Top module: `rx_addr_filter`

## Requirements
- R1: The address is broadcast when all 48 bits are one. Otherwise it is multicast when bit 0 of byte 0 (`dst_addr_i[40]`) is set, and unicast in every other case. Byte 0 is `dst_addr_i[47:40]`, and byte 5 is `dst_addr_i[7:0]`.
- R2: A broadcast frame is kept when `complement_i` or `acc_bcast_i` is set. Otherwise it is dropped with reason 1.
- R3: A multicast frame is kept when `complement_i` or `acc_mcast_i` is set. Otherwise it is dropped with reason 2.
- R4: A unicast frame is always kept, with reason 0, when `acc_all_ucast_i` is set.
- R5: A unicast hit requires three things: `cmp_en_i` is set, `entry_en_i[0]` is set, and all six address bytes equal the stored entry. The stored bytes 0..3 are `entry_hi_i[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Byte 4 is `entry_lo_i[31:24]` and byte 5 is `entry_lo_i[23:16]`. `entry_lo_i[15:0]` is ignored. With complement off, a hit is kept and a miss is dropped with reason 3.
- R6: With complement on, a unicast miss is kept and a hit is dropped with reason 4.
- R7: Only bit 0 of `entry_en_i` has any effect. The other bits never change the verdict.
- R8: `done_o`, `accept_o` and `reason_o` are zero during reset. `done_o` is high exactly in the cycle after a cycle with `valid_i` high. `accept_o` and `reason_o` keep their value when no request is made.
- R9: Reason 0 is reported exactly when the frame is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe for the address and settings of this cycle |
| dst_addr_i | input | 48 | Destination address, byte 0 in bits 47:40 |
| entry_hi_i | input | 32 | Station entry, bytes 0..3 |
| entry_lo_i | input | 32 | Station entry, bytes 4..5 in bits 31:16 |
| entry_en_i | input | 16 | Entry enable bits, only bit 0 honoured |
| cmp_en_i | input | 1 | Enable comparison against the station entry |
| acc_bcast_i | input | 1 | Keep broadcast frames |
| acc_mcast_i | input | 1 | Keep multicast frames |
| acc_all_ucast_i | input | 1 | Keep every unicast frame |
| complement_i | input | 1 | Invert the unicast comparison and keep all group frames |
| done_o | output | 1 | Verdict valid, one cycle after `valid_i` |
| accept_o | output | 1 | Frame kept |
| reason_o | output | 3 | 0 kept, 1 broadcast off, 2 multicast off, 3 unicast miss, 4 hit under complement |

## Verification
Every verdict is due exactly one rising edge after the request. The bench drives a request on a falling edge and compares `done_o`, `accept_o` and `reason_o` on the next falling edge, so one register stage separates stimulus from check.

On the cycle after that, it lowers `valid_i` and scrambles all inputs, then checks on the following falling edge that `done_o` has dropped and the verdict is unchanged. The sweep covers every combination of the five flags, four entry-enable patterns, and a set of addresses. That set includes a byte-by-byte mismatch for each of the six bytes and addresses that sit just next to the broadcast boundary.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  typedef enum logic [1:0] {
    CLS_UCAST = 2'd0,
    CLS_MCAST = 2'd1,
    CLS_BCAST = 2'd2
  } frame_cls_e;

  typedef enum logic [2:0] {
    RSN_OK       = 3'd0,
    RSN_BC_OFF   = 3'd1,
    RSN_MC_OFF   = 3'd2,
    RSN_UC_MISS  = 3'd3,
    RSN_HIT_CMPL = 3'd4
  } reason_e;
endpackage

// File: rtl/rxaf_classify.sv
module rxaf_classify
  import rxaf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W = ADDR_BYTES * 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output frame_cls_e        cls_o
);
  // group bit: LSB of the first byte on the wire
  localparam int GROUP_BIT = ADDR_W - 8;

  always_comb begin
    if (&addr_i)                cls_o = CLS_BCAST;
    else if (addr_i[GROUP_BIT]) cls_o = CLS_MCAST;
    else                        cls_o = CLS_UCAST;
  end
endmodule

// File: rtl/rxaf_match.sv
module rxaf_match #(
  parameter int ADDR_BYTES = 6,
  parameter int WORD_W     = 32,
  localparam int ADDR_W    = ADDR_BYTES * 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] entry_hi_i,
  input  logic [WORD_W-1:0] entry_lo_i,
  input  logic              entry_on_i,
  input  logic              cmp_en_i,
  output logic              hit_o
);
  localparam int PAIR_W = 2 * WORD_W;

  logic [PAIR_W-1:0]     pair;
  logic [ADDR_W-1:0]     stored;
  logic [ADDR_BYTES-1:0] byte_eq;

  assign pair   = {entry_hi_i, entry_lo_i};
  assign stored = pair[PAIR_W-1 -: ADDR_W];

  // trailing bits of the low word carry no address
  logic unused_tail;
  assign unused_tail = ^pair[PAIR_W-ADDR_W-1:0];

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
    assign byte_eq[b] = (addr_i[b*8 +: 8] == stored[b*8 +: 8]);
  end

  assign hit_o = cmp_en_i & entry_on_i & (&byte_eq);
endmodule

// File: rtl/rxaf_decide.sv
module rxaf_decide
  import rxaf_pkg::*;
(
  input  frame_cls_e cls_i,
  input  logic       hit_i,
  input  logic       acc_bcast_i,
  input  logic       acc_mcast_i,
  input  logic       acc_all_ucast_i,
  input  logic       complement_i,
  output logic       accept_o,
  output reason_e    reason_o
);
  always_comb begin
    accept_o = 1'b0;
    reason_o = RSN_OK;
    unique case (cls_i)
      CLS_BCAST: begin
        accept_o = complement_i | acc_bcast_i;
        reason_o = accept_o ? RSN_OK : RSN_BC_OFF;
      end
      CLS_MCAST: begin
        accept_o = complement_i | acc_mcast_i;
        reason_o = accept_o ? RSN_OK : RSN_MC_OFF;
      end
      default: begin
        if (acc_all_ucast_i) begin
          accept_o = 1'b1;
          reason_o = RSN_OK;
        end else if (complement_i) begin
          accept_o = ~hit_i;
          reason_o = hit_i ? RSN_HIT_CMPL : RSN_OK;
        end else begin
          accept_o = hit_i;
          reason_o = hit_i ? RSN_OK : RSN_UC_MISS;
        end
      end
    endcase
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxaf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int WORD_W     = 32,
  parameter int NUM_EN     = 16,
  localparam int ADDR_W    = ADDR_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [WORD_W-1:0] entry_hi_i,
  input  logic [WORD_W-1:0] entry_lo_i,
  input  logic [NUM_EN-1:0] entry_en_i,
  input  logic              cmp_en_i,
  input  logic              acc_bcast_i,
  input  logic              acc_mcast_i,
  input  logic              acc_all_ucast_i,
  input  logic              complement_i,
  output logic              done_o,
  output logic              accept_o,
  output logic [2:0]        reason_o
);
  frame_cls_e cls;
  logic       hit;
  logic       acc_d;
  reason_e    rsn_d;

  // only entry 0 exists
  logic unused_en;
  assign unused_en = ^entry_en_i[NUM_EN-1:1];

  rxaf_classify #(.ADDR_BYTES(ADDR_BYTES)) u_cls (
    .addr_i (dst_addr_i),
    .cls_o  (cls)
  );

  rxaf_match #(.ADDR_BYTES(ADDR_BYTES), .WORD_W(WORD_W)) u_match (
    .addr_i     (dst_addr_i),
    .entry_hi_i (entry_hi_i),
    .entry_lo_i (entry_lo_i),
    .entry_on_i (entry_en_i[0]),
    .cmp_en_i   (cmp_en_i),
    .hit_o      (hit)
  );

  rxaf_decide u_dec (
    .cls_i           (cls),
    .hit_i           (hit),
    .acc_bcast_i     (acc_bcast_i),
    .acc_mcast_i     (acc_mcast_i),
    .acc_all_ucast_i (acc_all_ucast_i),
    .complement_i    (complement_i),
    .accept_o        (acc_d),
    .reason_o        (rsn_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      accept_o <= 1'b0;
      reason_o <= RSN_OK;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        accept_o <= acc_d;
        reason_o <= rsn_d;
      end
    end
  end

  assert_done_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(accept_o) && $stable(reason_o)));
  assert_reason_ok_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (accept_o == (reason_o == RSN_OK)));
  assert_bcast_cmpl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls == CLS_BCAST && complement_i) |=> accept_o);
  assert_mcast_cmpl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls == CLS_MCAST && complement_i) |=> accept_o);
  assert_ucast_all_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls == CLS_UCAST && acc_all_ucast_i) |=> accept_o);
  assert_hit_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (cmp_en_i && entry_en_i[0]));
  assert_hit_cmpl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cls == CLS_UCAST && !acc_all_ucast_i && complement_i && hit)
    |=> (reason_o == RSN_HIT_CMPL));
  assert_group_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls == CLS_MCAST) |-> dst_addr_i[ADDR_W-8]);
endmodule

// File: tb/tb_rx_addr_filter.sv
module tb_rx_addr_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [47:0] dst_addr_i = '0;
  logic [31:0] entry_hi_i = '0;
  logic [31:0] entry_lo_i = '0;
  logic [15:0] entry_en_i = '0;
  logic        cmp_en_i = 1'b0, acc_bcast_i = 1'b0, acc_mcast_i = 1'b0;
  logic        acc_all_ucast_i = 1'b0, complement_i = 1'b0;
  logic        done_o, accept_o;
  logic [2:0]  reason_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  rx_addr_filter dut (.*);

  localparam logic [47:0] ENTRY = 48'h02_1a_3c_55_77_9e;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] pat(input int p);
    case (p)
      0:       return '1;
      1:       return 48'h01_00_5e_00_00_fb;
      2:       return ENTRY;
      9:       return 48'hff_ff_ff_ff_ff_fe;  // R1: byte0 odd -> multicast
      10:      return 48'hfe_ff_ff_ff_ff_ff;  // R1: byte0 even -> unicast
      default: return ENTRY ^ (48'h80 << (8 * (5 - (p - 3))));
    endcase
  endfunction

  function automatic logic [15:0] en_pat(input int e);
    case (e)
      0: return 16'h0001;
      1: return 16'h0000;
      2: return 16'hfffe;
      default: return 16'hffff;
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic       exp_acc;
    logic [2:0] exp_rsn;
    logic       hit;
    string      tag;
    repeat (3) @(negedge clk_i);
    check("R8 reset done", {31'b0, done_o}, 0);
    check("R8 reset accept", {31'b0, accept_o}, 0);
    check("R8 reset reason", {29'b0, reason_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int p = 0; p < 11; p++) begin
      for (int e = 0; e < 4; e++) begin
        for (int f = 0; f < 32; f++) begin
          dst_addr_i      = pat(p);
          entry_hi_i      = ENTRY[47:16];
          entry_lo_i      = {ENTRY[15:0], 16'(p * 977 + f * 31 + e)};  // low half is don't-care
          entry_en_i      = en_pat(e);
          {cmp_en_i, acc_bcast_i, acc_mcast_i, acc_all_ucast_i, complement_i} = 5'(f);
          valid_i = 1'b1;
          // reference model
          hit = cmp_en_i && entry_en_i[0] && (dst_addr_i == ENTRY);
          if (&dst_addr_i) begin
            exp_acc = complement_i | acc_bcast_i; exp_rsn = exp_acc ? 3'd0 : 3'd1; tag = "R2";
          end else if (dst_addr_i[40]) begin
            exp_acc = complement_i | acc_mcast_i; exp_rsn = exp_acc ? 3'd0 : 3'd2; tag = "R3";
          end else if (acc_all_ucast_i) begin
            exp_acc = 1'b1; exp_rsn = 3'd0; tag = "R4";
          end else if (complement_i) begin
            exp_acc = !hit; exp_rsn = hit ? 3'd4 : 3'd0; tag = "R6";
          end else begin
            exp_acc = hit; exp_rsn = hit ? 3'd0 : 3'd3; tag = "R5";
          end
          if (p >= 9) tag = "R1";
          else if (e >= 2) tag = "R7";
          @(negedge clk_i);
          check({tag, " accept"}, {31'b0, accept_o}, {31'b0, exp_acc});
          check({tag, " reason"}, {29'b0, reason_o}, {29'b0, exp_rsn});
          check("R8 done", {31'b0, done_o}, 1);
          check("R9 reason0 iff accept", {31'b0, accept_o}, {31'b0, reason_o == 3'd0});
          // idle cycle with scrambled inputs: verdict must hold
          valid_i = 1'b0;
          dst_addr_i = ~dst_addr_i;
          {cmp_en_i, acc_bcast_i, acc_mcast_i, acc_all_ucast_i, complement_i} = ~5'(f);
          @(negedge clk_i);
          check("R8 idle done", {31'b0, done_o}, 0);
          check("R8 hold accept", {31'b0, accept_o}, {31'b0, exp_acc});
          check("R8 hold reason", {29'b0, reason_o}, {29'b0, exp_rsn});
        end
      end
    end
    finish_run();
  end
endmodule